// File: doc/BRIEF.md
# Row-Buffered DRAM Front End with SRAM-Style Port

This block lets user logic treat an embedded synchronous DRAM core as if it were a pipelined SRAM. User logic presents a request strobe, a read/write select, an address and write data. The block splits the address into a column, a row-buffer index and a row tag. It keeps one tag and one valid bit per row buffer, so the open rows act as a direct-mapped cache. A request whose tag matches the open row of its buffer is a hit and goes straight to a column command. Any other request closes the old row if one is open, opens the new row, and then issues the column command.

While the block is busy the user port sees a `stall` output. Each hazard class has its own penalty: a row miss, a write that immediately follows a read (bus turnaround), and a clock-phase slip flagged by the DRAM clock domain. When several of these hit the same request, the stall length is the largest penalty among them, not their sum. A host halt input requests refresh. The port stays stalled for as long as the halt is held, and one refresh command goes to the core. Every row buffer is invalidated, so the first access to each buffer after a halt is a miss. Read data comes back in request order with a valid flag after a fixed latency. Cell-array timing is abstracted as parameterised latencies.

Top module: `rowbuf_sram_front`

## Requirements
- R1: A request is accepted on a rising clock edge where `req` is high and `stall` is low. A request presented while `stall` is high has no effect, and a write presented during a halt leaves memory unchanged.
- R2: A read that hits with no hazard is accepted in cycle a and returns `rd_valid` with its data in cycle a+6. This is CAS_LAT+2 cycles with CAS_LAT=4.
- R3: A request with no hazard raises no stall, so such requests can be accepted on consecutive cycles.
- R4: A row-buffer miss holds `stall` high for exactly MISS_PEN=10 cycles after the accepting edge, and its read data arrives in cycle a+16. Before the column command, the core receives a precharge of the buffer's bank only if a row was open there, then an activate of the new row.
- R5: A write accepted on the cycle right after an accepted read holds `stall` high for exactly WAR_PEN=4 cycles.
- R6: A request accepted while `phase_slip` is high holds `stall` high for exactly ALIGN_PEN=1 cycle.
- R7: When hazards coincide, the stall length is the maximum of their penalties.
- R8: While `halt` is high, `stall` is high. Exactly one refresh command (`dram_cmd`=5) is issued per halt period once the block is idle.
- R9: A halt invalidates every row buffer. The next access to any buffer counts as a miss (R4 stall), and no precharge is issued for it.
- R10: Write data is captured in the accepting cycle, and a later read of the same address returns it.
- R11: Read data returns in the order the reads were accepted.

The address is laid out as {tag, index, column}, with the column in the low COL_W bits. Command codes on `dram_cmd` are 0 no-op, 1 precharge, 2 activate, 3 read, 4 write and 5 refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address {tag, index, column} |
| wdata | input | DATA_W | Write data |
| phase_slip | input | 1 | DRAM/logic clock-phase slip this cycle |
| halt | input | 1 | Host refresh halt |
| stall | output | 1 | User logic must hold off |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| dram_cmd | output | 3 | Command to the DRAM core |
| dram_bank | output | IDX_W | Row-buffer (bank) select |
| dram_row | output | TAG_W | Row address for activate |
| dram_col | output | COL_W | Column address |
| dram_wdata | output | DATA_W | Write data to the core |
| dram_rdata | input | DATA_W | Read data from the core, CAS_LAT cycles after a read command |

## Verification
Each request's stall penalty is known from the accepting cycle onward: the bench keeps its own tag table and read/write history, takes the largest applicable penalty p, and expects `stall` high on each of the next p cycles and low on the one after. A read presented in cycle a must return in cycle a+6+p. The bench records that due cycle together with the expected data from its own memory image, and checks the `rd_valid` pulse against the oldest due entry at the falling edge of that exact cycle. A missing pulse is reported once its due cycle has passed. A behavioural core model counts protocol violations (column access to a closed bank, activate of an open bank, precharge of a closed bank) and refresh commands, and the bench checks those counts after each phase.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_REF = 3'd5
  } dram_cmd_e;

  // Stall length of one request: largest penalty of the hazards present (R7).
  function automatic int unsigned rbf_stall_len(
    input logic        miss,
    input logic        war,
    input logic        slip,
    input int unsigned miss_pen,
    input int unsigned war_pen,
    input int unsigned align_pen
  );
    int unsigned len;
    len = 0;
    if (miss && miss_pen > len) len = miss_pen;
    if (war && war_pen > len)   len = war_pen;
    if (slip && align_pen > len) len = align_pen;
    return len;
  endfunction

endpackage

// File: rtl/rbf_row_tags.sv
module rbf_row_tags #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              upd,
  input  logic              clr,
  output logic              hit,
  output logic              open,
  output logic [(1<<IDX_W)-1:0] valid_vec
);
  localparam int NBUF = 1 << IDX_W;

  logic [TAG_W-1:0] tag_arr [NBUF];

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (clr) begin
        v_q <= 1'b0;
      end else if (upd && lk_idx == IDX_W'(g)) begin
        v_q <= 1'b1;
        t_q <= lk_tag;
      end
    end
    assign valid_vec[g] = v_q;
    assign tag_arr[g]   = t_q;
  end

  assign open = valid_vec[lk_idx];
  assign hit  = open && (tag_arr[lk_idx] == lk_tag);
endmodule

// File: rtl/rbf_cmd_seq.sv
module rbf_cmd_seq
  import rbf_pkg::*;
#(
  parameter int DATA_W   = 128,
  parameter int COL_W    = 3,
  parameter int IDX_W    = 2,
  parameter int TAG_W    = 13,
  parameter int MISS_PEN = 10,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              acc_we,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [TAG_W-1:0]  acc_tag,
  input  logic [COL_W-1:0]  acc_col,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [CNT_W-1:0]  acc_pen,
  input  logic              acc_miss,
  input  logic              acc_pre,
  input  logic              halt,
  output logic              busy,
  output logic [2:0]        cmd,
  output logic [IDX_W-1:0]  bank,
  output logic [TAG_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_issue
);
  localparam int ACT_AT = MISS_PEN / 2;

  logic              h_v, h_we, h_miss, h_pre, ref_sent;
  logic [IDX_W-1:0]  h_idx;
  logic [TAG_W-1:0]  h_tag;
  logic [COL_W-1:0]  h_col;
  logic [DATA_W-1:0] h_wdata;
  logic [CNT_W-1:0]  h_cnt;
  dram_cmd_e         cmd_e;

  wire col_now = h_v && (h_cnt == '0);
  wire pre_now = h_v && h_pre && (h_cnt == CNT_W'(MISS_PEN));
  wire act_now = h_v && h_miss && (h_cnt == CNT_W'(ACT_AT));
  wire ref_now = halt && !h_v && !ref_sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_v <= 1'b0; h_we <= 1'b0; h_miss <= 1'b0; h_pre <= 1'b0;
      h_idx <= '0; h_tag <= '0; h_col <= '0; h_wdata <= '0; h_cnt <= '0;
    end else if (acc) begin
      h_v     <= 1'b1;
      h_we    <= acc_we;
      h_miss  <= acc_miss;
      h_pre   <= acc_pre;
      h_idx   <= acc_idx;
      h_tag   <= acc_tag;
      h_col   <= acc_col;
      h_wdata <= acc_wdata;
      h_cnt   <= acc_pen;
    end else if (h_v) begin
      if (h_cnt == '0) h_v <= 1'b0;
      else             h_cnt <= h_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ref_sent <= 1'b0;
    else if (!halt)   ref_sent <= 1'b0;
    else if (ref_now) ref_sent <= 1'b1;
  end

  always_comb begin
    if (col_now)      cmd_e = h_we ? CMD_WR : CMD_RD;
    else if (pre_now) cmd_e = CMD_PRE;
    else if (act_now) cmd_e = CMD_ACT;
    else if (ref_now) cmd_e = CMD_REF;
    else              cmd_e = CMD_NOP;
  end

  assign cmd      = cmd_e;
  assign bank     = h_idx;
  assign row      = h_tag;
  assign col      = h_col;
  assign wdata_o  = h_wdata;
  assign rd_issue = (cmd_e == CMD_RD);
  assign busy     = h_v && (h_cnt != '0);
endmodule

// File: rtl/rbf_read_return.sv
module rbf_read_return #(
  parameter int DATA_W  = 128,
  parameter int CAS_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] dram_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [CAS_LAT-1:0] vpipe;

  if (CAS_LAT == 1) begin : g_short
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= rd_issue;
    end
  end else begin : g_long
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[CAS_LAT-2:0], rd_issue};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= vpipe[CAS_LAT-1];
      if (vpipe[CAS_LAT-1]) rd_data <= dram_rdata;
    end
  end
endmodule

// File: rtl/rowbuf_sram_front.sv
module rowbuf_sram_front
  import rbf_pkg::*;
#(
  parameter int DATA_W    = 128,
  parameter int ADDR_W    = 18,
  parameter int COL_W     = 3,
  parameter int IDX_W     = 2,
  parameter int MISS_PEN  = 10,
  parameter int WAR_PEN   = 4,
  parameter int ALIGN_PEN = 1,
  parameter int CAS_LAT   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  input  logic                            phase_slip,
  input  logic                            halt,
  output logic                            stall,
  output logic                            rd_valid,
  output logic [DATA_W-1:0]               rd_data,
  output logic [2:0]                      dram_cmd,
  output logic [IDX_W-1:0]                dram_bank,
  output logic [ADDR_W-COL_W-IDX_W-1:0]   dram_row,
  output logic [COL_W-1:0]                dram_col,
  output logic [DATA_W-1:0]               dram_wdata,
  input  logic [DATA_W-1:0]               dram_rdata
);
  localparam int TAG_W = ADDR_W - COL_W - IDX_W;
  localparam int NBUF  = 1 << IDX_W;
  localparam int CNT_W = $clog2(MISS_PEN + 1);

  logic [COL_W-1:0] a_col;
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;
  logic             acc, row_hit, row_miss, row_open, war_haz, prev_rd, busy, rd_issue;
  logic [NBUF-1:0]  valid_vec;
  logic [CNT_W-1:0] pen;

  assign {a_tag, a_idx, a_col} = addr;

  assign stall    = halt | busy;
  assign acc      = req & ~stall;
  assign row_miss = ~row_hit;
  assign war_haz  = we & prev_rd;
  assign pen      = CNT_W'(rbf_stall_len(row_miss, war_haz, phase_slip,
                                         MISS_PEN, WAR_PEN, ALIGN_PEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_rd <= 1'b0;
    else        prev_rd <= acc & ~we;
  end

  rbf_row_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_idx(a_idx), .lk_tag(a_tag),
    .upd(acc), .clr(halt), .hit(row_hit), .open(row_open), .valid_vec(valid_vec)
  );

  rbf_cmd_seq #(
    .DATA_W(DATA_W), .COL_W(COL_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .MISS_PEN(MISS_PEN), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_we(we), .acc_idx(a_idx),
    .acc_tag(a_tag), .acc_col(a_col), .acc_wdata(wdata), .acc_pen(pen),
    .acc_miss(row_miss), .acc_pre(row_miss & row_open), .halt(halt),
    .busy(busy), .cmd(dram_cmd), .bank(dram_bank), .row(dram_row),
    .col(dram_col), .wdata_o(dram_wdata), .rd_issue(rd_issue)
  );

  rbf_read_return #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_ret (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .dram_rdata(dram_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/rowbuf_sram_front_chk.sv
module rowbuf_sram_front_chk #(
  parameter int NBUF = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            halt,
  input logic            stall,
  input logic            acc,
  input logic            row_miss,
  input logic            war_haz,
  input logic            phase_slip,
  input logic [NBUF-1:0] valid_vec
);
  assert_halt_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> stall);

  assert_miss_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && row_miss) |=> stall);

  assert_turnaround_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && war_haz) |=> stall);

  assert_slip_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && phase_slip) |=> stall);

  assert_clean_hit_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !row_miss && !war_haz && !phase_slip) |=> (stall == halt));

  assert_halt_invalidates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (valid_vec == '0));
endmodule

bind rowbuf_sram_front rowbuf_sram_front_chk #(.NBUF(NBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .stall(stall), .acc(acc),
  .row_miss(row_miss), .war_haz(war_haz), .phase_slip(phase_slip),
  .valid_vec(valid_vec)
);

// File: tb/rowbuf_sram_front_bench.sv
module rowbuf_sram_front_bench;
  import rbf_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32, ADDR_W = 7, COL_W = 3, IDX_W = 2;
  localparam int TAG_W = ADDR_W - COL_W - IDX_W;
  localparam int NBUF = 1 << IDX_W, NWORDS = 1 << ADDR_W;
  localparam int MISS = 10, WARP = 4, SLIP = 1, CAS = 4, BASE_LAT = CAS + 2;

  logic clk = 0, rst_n = 0, req = 0, we = 0, phase_slip = 0, halt = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic stall, rd_valid;
  logic [DATA_W-1:0] rd_data, dram_wdata, dram_rdata;
  logic [2:0] dram_cmd;
  logic [IDX_W-1:0] dram_bank;
  logic [TAG_W-1:0] dram_row;
  logic [COL_W-1:0] dram_col;

  rowbuf_sram_front #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .IDX_W(IDX_W),
    .MISS_PEN(MISS), .WAR_PEN(WARP), .ALIGN_PEN(SLIP), .CAS_LAT(CAS)
  ) u_rowbuf_sram_front (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .phase_slip(phase_slip), .halt(halt), .stall(stall), .rd_valid(rd_valid),
    .rd_data(rd_data), .dram_cmd(dram_cmd), .dram_bank(dram_bank),
    .dram_row(dram_row), .dram_col(dram_col), .dram_wdata(dram_wdata),
    .dram_rdata(dram_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, checks = 0, fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string rq, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic logic [DATA_W-1:0] seed(int i);
    return DATA_W'(32'hA5000000 ^ (i * 32'h00010203));
  endfunction

  // Behavioural DRAM core: open row per bank, CAS pipeline, protocol counters.
  logic [DATA_W-1:0] dmem [NWORDS];
  logic [TAG_W-1:0]  open_row [NBUF];
  bit                open_v [NBUF];
  logic [DATA_W-1:0] dpipe [CAS];
  int proto_err = 0, ref_cnt = 0;
  assign dram_rdata = dpipe[CAS-1];

  initial begin
    for (int i = 0; i < NWORDS; i++) dmem[i] = seed(i);
    for (int b = 0; b < NBUF; b++) open_v[b] = 0;
    for (int k = 0; k < CAS; k++) dpipe[k] = '0;
  end

  always @(posedge clk) begin
    for (int k = CAS - 1; k > 0; k--) dpipe[k] <= dpipe[k-1];
    dpipe[0] <= '0;
    case (dram_cmd)
      3'(CMD_RD): if (!open_v[dram_bank]) proto_err++;
                  else dpipe[0] <= dmem[{open_row[dram_bank], dram_bank, dram_col}];
      3'(CMD_WR): if (!open_v[dram_bank]) proto_err++;
                  else dmem[{open_row[dram_bank], dram_bank, dram_col}] <= dram_wdata;
      3'(CMD_ACT): begin
        if (open_v[dram_bank]) proto_err++;
        open_v[dram_bank] = 1;
        open_row[dram_bank] = dram_row;
      end
      3'(CMD_PRE): begin
        if (!open_v[dram_bank]) proto_err++;
        open_v[dram_bank] = 0;
      end
      3'(CMD_REF): begin
        ref_cnt++;
        for (int b = 0; b < NBUF; b++) open_v[b] = 0;
      end
      default: ;
    endcase
  end

  // Bench reference state.
  logic [DATA_W-1:0] refm [NWORDS];
  bit                tb_v [NBUF];
  int                tb_t [NBUF];
  bit                last_rd = 0;
  int                last_cyc = -10;
  int                due_q [$];
  logic [DATA_W-1:0] dat_q [$];

  // Read return monitor (R2 R4 R10 R11).
  always @(negedge clk) if (rst_n) begin
    if (rd_valid) begin
      if (due_q.size() == 0) chk(0, "R11 unexpected rd_valid", 1, 0);
      else begin
        chk(cyc == due_q[0], "R2 R4 read latency", cyc, due_q[0]);
        chk(rd_data == dat_q[0], "R10 R11 read data", rd_data, dat_q[0]);
        void'(due_q.pop_front());
        void'(dat_q.pop_front());
      end
    end else if (due_q.size() > 0 && due_q[0] < cyc) begin
      chk(0, "R2 R4 missing rd_valid", cyc, due_q[0]);
      void'(due_q.pop_front());
      void'(dat_q.pop_front());
    end
  end

  // Presents one request at a falling edge and checks its stall window.
  task automatic issue(bit w, int a, logic [DATA_W-1:0] d, bit slip, string rq);
    int idx, tg, pen;
    bit miss, war;
    while (stall) @(negedge clk);
    idx  = (a >> COL_W) % NBUF;
    tg   = a >> (COL_W + IDX_W);
    miss = !(tb_v[idx] && tb_t[idx] == tg);
    war  = w && last_rd && (last_cyc == cyc - 1);
    pen  = 0;
    if (miss) pen = MISS;
    if (war && WARP > pen) pen = WARP;
    if (slip && SLIP > pen) pen = SLIP;
    req = 1; we = w; addr = ADDR_W'(a); wdata = d; phase_slip = slip;
    tb_v[idx] = 1; tb_t[idx] = tg; last_rd = !w; last_cyc = cyc;
    if (w) refm[a] = d;
    else begin
      due_q.push_back(cyc + BASE_LAT + pen);
      dat_q.push_back(refm[a]);
    end
    @(negedge clk);
    req = 0; we = 0; phase_slip = 0;
    for (int k = 1; k <= pen; k++) begin
      chk(stall == 1'b1, rq, stall, 1);
      @(negedge clk);
    end
    chk(stall == 1'b0, rq, stall, 0);
  endtask

  task automatic drain();
    repeat (MISS + BASE_LAT + 4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) refm[i] = seed(i);
    for (int b = 0; b < NBUF; b++) begin tb_v[b] = 0; tb_t[b] = 0; end
    repeat (3) @(negedge clk);
    chk(stall == 1'b0, "R1 reset stall", stall, 0);
    chk(rd_valid == 1'b0, "R1 reset rd_valid", rd_valid, 0);
    chk(dram_cmd == 3'(CMD_NOP), "R1 reset command", dram_cmd, 0);
    rst_n = 1;
    @(negedge clk);

    // R4: cold miss, then R2 R3 R11 back-to-back hits in the same row.
    issue(0, 0, '0, 0, "R4 cold miss stall");
    for (int c = 1; c < 8; c++) issue(0, c, '0, 0, "R3 streaming hit stall");

    // Near-exhaustive sweeps: linear, then strided to thrash the buffers (R4 R9).
    for (int a = 0; a < NWORDS; a++) issue(0, a, '0, 0, "R3 R4 linear sweep stall");
    for (int i = 0; i < NWORDS; i++) issue(0, (i * 37) % NWORDS, '0, 0, "R4 strided sweep stall");

    // R5 R10: read, hit read, then turnaround write; read back afterwards.
    for (int a = 0; a < 16; a++) begin
      issue(0, a + 40, '0, 0, "R4 pre-write read");
      issue(0, a + 40, '0, 0, "R3 pre-write hit");
      issue(1, a + 40, ~seed(a) ^ DATA_W'(a), 0, "R5 turnaround stall");
    end
    for (int a = 0; a < 16; a++) issue(0, a + 40, '0, 0, "R10 read-back stall");

    // R6 R7: phase slip alone and combined with other hazards.
    issue(0, 8, '0, 0, "R4 slip setup");
    issue(0, 9, '0, 1, "R6 slip on hit");
    issue(0, 10, '0, 0, "R3 slip setup hit");
    issue(1, 10, DATA_W'(32'h0BADF00D), 1, "R7 slip plus turnaround");
    issue(0, 8 + 64, '0, 1, "R7 slip plus miss");
    issue(0, 10, '0, 0, "R7 reopen");

    // R8 R9 R1: halt with a write held on the port, then access after refresh.
    drain();
    begin
      int r0;
      r0 = ref_cnt;
      halt = 1; req = 1; we = 1; addr = ADDR_W'(10); wdata = DATA_W'(32'hDEAD0001);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(stall == 1'b1, "R8 stall during halt", stall, 1);
      end
      req = 0; we = 0;
      @(negedge clk);
      halt = 0;
      for (int b = 0; b < NBUF; b++) tb_v[b] = 0;
      @(negedge clk);
      chk(ref_cnt - r0 == 1, "R8 one refresh per halt", ref_cnt - r0, 1);
    end
    issue(0, 10, '0, 0, "R9 miss after refresh");
    issue(0, 11, '0, 0, "R3 hit after refresh");

    drain();
    chk(due_q.size() == 0, "R11 all reads returned", due_q.size(), 0);
    chk(proto_err == 0, "R4 R9 core command order", proto_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule